// File: doc/BRIEF.md
# Byte-Wide Indirect Register Port

This block lets a host with an 8-bit data bus and a 3-bit address reach a wide internal register space. The host loads a few holding locations with a channel number, a register address inside that channel and up to three upper data bytes. It then writes the lowest data byte. That final write commits the whole assembled word to the internal write bus as one transaction.

The internal side sees a channel, an address, a 32-bit data word and a one-cycle strobe. The holding locations keep their contents after a commit. A host that updates only the low byte of a sequence of registers therefore rewrites just that byte. Every holding location reads back on the same bus. Two external addresses are left unused.

Top module: `byte_reg_port`

## Requirements
- R1: After reset every holding location reads back as zero and the internal strobe is low.
- R2: A write to external address 7 stores the channel byte, which then reads back at address 7 and drives the internal channel output on the next commit.
- R3: A write to external address 6 stores the internal register address byte, which then reads back at address 6 and drives the internal address output on the next commit.
- R4: Writes to external addresses 3, 2 and 1 store data bytes 3, 2 and 1 (byte 3 most significant) and never raise the internal strobe.
- R5: A write to external address 0 raises the internal strobe for exactly one cycle, in the cycle after the clock edge that samples the write.
- R6: While the strobe is high, the internal data equals {byte 3, byte 2, byte 1, the byte written to address 0}, and the channel and address outputs equal the held channel and address bytes.
- R7: A commit leaves all holding locations unchanged apart from byte 0. A later write to address 0 alone commits a new word that reuses the held upper bytes, channel and address.
- R8: Writes to external addresses 4 and 5 change no holding location and produce no strobe, and reads from those addresses return zero.
- R9: With the write enable low, bus data and address changes alter no holding location and produce no strobe.
- R10: The internal channel, address and data outputs keep their last committed values until the next commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Host write enable, sampled on the clock edge |
| bus_addr | input | 3 | Host external address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for the location at bus_addr (combinational) |
| iw_chan | output | CHAN_W | Channel of the committed write |
| iw_addr | output | IADDR_W | Internal register address of the committed write |
| iw_data | output | 32 | Committed data word |
| iw_strobe | output | 1 | One-cycle internal write strobe |

## Verification
A corrupted holding byte stays hidden from the internal side until the next commit. It is visible at once on bus_rdata, however, when its address is presented. The bench compares bus_rdata for the current address on every cycle, so such a fault shows within one cycle of the bad write. A misdecoded commit shows as a strobe one cycle after the wrong write, or a missing strobe after a write to address 0. A wrongly packed word shows in iw_data during that same strobe cycle and persists until the next commit.

// File: rtl/brp_pkg.sv
package brp_pkg;
  localparam int BYTE_W   = 8;
  localparam int EXT_AW   = 3;
  localparam int SLOTS    = 1 << EXT_AW;
  localparam int WORD_BYT = 4;
  localparam int WORD_W   = WORD_BYT * BYTE_W;

  localparam logic [EXT_AW-1:0] A_BYTE0 = 3'd0;
  localparam logic [EXT_AW-1:0] A_IADDR = 3'd6;
  localparam logic [EXT_AW-1:0] A_CHAN  = 3'd7;

  typedef logic [BYTE_W-1:0] byte_t;

  // Slots 4 and 5 carry no storage.
  function automatic logic slot_used(input int unsigned s);
    return (s != 4) && (s != 5);
  endfunction

  // Assemble the committed word: held bytes 3..1 above the fresh byte 0.
  function automatic logic [WORD_W-1:0] pack_word(input byte_t b3, input byte_t b2,
                                                  input byte_t b1, input byte_t b0);
    return {b3, b2, b1, b0};
  endfunction
endpackage

// File: rtl/brp_decode.sv
module brp_decode
  import brp_pkg::*;
(
  input  logic              we,
  input  logic [EXT_AW-1:0] addr,
  output logic [SLOTS-1:0]  slot_we,
  output logic              commit_fire
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_dec
    if (slot_used(s)) begin : g_on
      assign slot_we[s] = we && (addr == EXT_AW'(s));
    end else begin : g_off
      assign slot_we[s] = 1'b0;
    end
  end

  assign commit_fire = we && (addr == A_BYTE0);
endmodule

// File: rtl/brp_hold.sv
module brp_hold
  import brp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SLOTS-1:0]       slot_we,
  input  byte_t                  wdata,
  input  logic [EXT_AW-1:0]      rd_addr,
  output logic [SLOTS-1:0][BYTE_W-1:0] hold_q,
  output byte_t                  rdata
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (slot_used(s)) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          hold_q[s] <= '0;
        else if (slot_we[s]) hold_q[s] <= wdata;
      end
    end else begin : g_none
      assign hold_q[s] = '0;
    end
  end

  assign rdata = hold_q[rd_addr];
endmodule

// File: rtl/brp_commit.sv
module brp_commit
  import brp_pkg::*;
#(
  parameter int CHAN_W  = 8,
  parameter int IADDR_W = 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  byte_t              chan_b,
  input  byte_t              iaddr_b,
  input  byte_t              b3,
  input  byte_t              b2,
  input  byte_t              b1,
  input  byte_t              b0_new,
  output logic               strobe,
  output logic [CHAN_W-1:0]  chan,
  output logic [IADDR_W-1:0] iaddr,
  output logic [WORD_W-1:0]  data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe <= 1'b0;
      chan   <= '0;
      iaddr  <= '0;
      data   <= '0;
    end else begin
      strobe <= fire;
      if (fire) begin
        chan  <= chan_b[CHAN_W-1:0];
        iaddr <= iaddr_b[IADDR_W-1:0];
        data  <= pack_word(b3, b2, b1, b0_new);
      end
    end
  end
endmodule

// File: rtl/byte_reg_port.sv
module byte_reg_port
  import brp_pkg::*;
#(
  parameter int CHAN_W  = 8,
  parameter int IADDR_W = 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [2:0]         bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic [CHAN_W-1:0]  iw_chan,
  output logic [IADDR_W-1:0] iw_addr,
  output logic [31:0]        iw_data,
  output logic               iw_strobe
);
  logic [SLOTS-1:0]             slot_we;
  logic                         commit_fire;
  logic [SLOTS-1:0][BYTE_W-1:0] hold_q;
  logic [3*BYTE_W-1:0]          upper_q;

  brp_decode u_dec (
    .we(bus_we), .addr(bus_addr), .slot_we(slot_we), .commit_fire(commit_fire)
  );

  brp_hold u_hold (
    .clk(clk), .rst_n(rst_n), .slot_we(slot_we), .wdata(bus_wdata),
    .rd_addr(bus_addr), .hold_q(hold_q), .rdata(bus_rdata)
  );

  assign upper_q = {hold_q[3], hold_q[2], hold_q[1]};

  brp_commit #(.CHAN_W(CHAN_W), .IADDR_W(IADDR_W)) u_cmt (
    .clk(clk), .rst_n(rst_n), .fire(commit_fire),
    .chan_b(hold_q[A_CHAN]), .iaddr_b(hold_q[A_IADDR]),
    .b3(hold_q[3]), .b2(hold_q[2]), .b1(hold_q[1]), .b0_new(bus_wdata),
    .strobe(iw_strobe), .chan(iw_chan), .iaddr(iw_addr), .data(iw_data)
  );
endmodule

// File: rtl/byte_reg_port_chk.sv
module byte_reg_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic [31:0] iw_data,
  input logic        iw_strobe,
  input logic        commit_fire,
  input logic [23:0] upper_q
);
  // R5: a byte-0 write is followed by the strobe
  a_r5_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0) |=> iw_strobe);
  // R4 / R8 / R9: no strobe without a byte-0 write the cycle before
  a_r4_only_byte0_commits: assert property (@(posedge clk) disable iff (!rst_n)
    iw_strobe |-> $past(bus_we && bus_addr == 3'd0));
  // R6: low byte of the committed word is the byte-0 write data
  a_r6_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> (iw_data[7:0] == $past(bus_wdata)));
  // R6: upper bytes come from the holding locations
  a_r6_upper_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> (iw_data[31:8] == $past(upper_q)));
  // R7: a byte-0 write leaves the upper holding bytes unchanged
  a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> $stable(upper_q));
  // R10: committed data holds between strobes
  a_r10_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !iw_strobe |-> $stable(iw_data));
  // R8: unused addresses read zero
  a_r8_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd4 || bus_addr == 3'd5) |-> (bus_rdata == 8'h00));
endmodule

bind byte_reg_port byte_reg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .iw_data(iw_data),
  .iw_strobe(iw_strobe), .commit_fire(commit_fire), .upper_q(upper_q)
);

// File: tb/byte_reg_port_test.sv
`timescale 1ns/1ps
module byte_reg_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [7:0]  iw_chan, iw_addr;
  logic [31:0] iw_data;
  logic        iw_strobe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int unsigned m_hold [8];
  int unsigned m_chan = 0, m_addr = 0, m_data = 0;
  bit          m_strobe = 1'b0;

  always #2 clk = ~clk;

  byte_reg_port uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .iw_chan(iw_chan),
    .iw_addr(iw_addr), .iw_data(iw_data), .iw_strobe(iw_strobe)
  );

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int a);
    case (a)
      7: return "R2";
      6: return "R3";
      1, 2, 3: return "R4";
      0: return "R7";
      default: return "R8";
    endcase
  endfunction

  // cycle model: update at the edge, compare mid-high
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_hold[i]) m_hold[i] = 0;
      m_strobe = 0; m_chan = 0; m_addr = 0; m_data = 0;
    end else begin
      m_strobe = bus_we && (bus_addr == 3'd0);
      if (m_strobe) begin
        m_data = (m_hold[3] << 24) | (m_hold[2] << 16) | (m_hold[1] << 8) | bus_wdata;
        m_chan = m_hold[7];
        m_addr = m_hold[6];
      end
      if (bus_we && bus_addr != 3'd4 && bus_addr != 3'd5)
        m_hold[bus_addr] = bus_wdata;
    end
    #1;
    if (rst_n && !done) begin
      check(tag_of(bus_addr), "readback", bus_rdata, m_hold[bus_addr]);
      check("R5", "strobe", iw_strobe, m_strobe);
      check("R6", "data", iw_data, m_data);
      check("R10", "chan", iw_chan, m_chan);
      check("R10", "addr", iw_addr, m_addr);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic peek(input int a, output int v);
    @(negedge clk);
    bus_addr = 3'(a);
    #1 v = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      peek(a, v);
      check("R1", "reset readback", v, 0);
    end
    check("R1", "reset strobe", iw_strobe, 0);
    // R2, R3, R4: load holding locations
    wr(7, 8'h02); wr(6, 8'h41);
    wr(3, 8'hA5); wr(2, 8'hC3); wr(1, 8'h7E);
    check("R4", "no strobe after upper bytes", iw_strobe, 0);
    peek(7, v); check("R2", "chan readback", v, 8'h02);
    peek(6, v); check("R3", "addr readback", v, 8'h41);
    // R5, R6: commit
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h19;
    @(negedge clk);
    bus_we = 1'b0;
    check("R5", "strobe high after byte0", iw_strobe, 1);
    check("R6", "word", iw_data, 32'hA5C37E19);
    check("R2", "iw_chan", iw_chan, 8'h02);
    check("R3", "iw_addr", iw_addr, 8'h41);
    @(negedge clk);
    check("R5", "strobe single cycle", iw_strobe, 0);
    // R7: byte0-only reuse
    wr(0, 8'h55);
    check("R7", "reused upper bytes", iw_data, 32'hA5C37E55);
    peek(3, v); check("R7", "byte3 kept", v, 8'hA5);
    // R8: unused addresses
    wr(4, 8'hFF); wr(5, 8'hEE);
    peek(4, v); check("R8", "addr4 reads zero", v, 0);
    peek(5, v); check("R8", "addr5 reads zero", v, 0);
    check("R8", "no strobe", iw_strobe, 0);
    // R9: no enable, changing data/address
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      bus_addr = 3'(k); bus_wdata = 8'(8'h30 + k);
    end
    peek(1, v); check("R9", "byte1 untouched", v, 8'h7E);
    check("R9", "no strobe", iw_strobe, 0);
    // R10: outputs hold
    check("R10", "data held", iw_data, 32'hA5C37E55);
    // back-to-back commits with new channel and bytes
    wr(7, 8'h0C); wr(2, 8'h00);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h01;
    @(negedge clk);
    bus_wdata = 8'h02;
    check("R6", "first of pair", iw_data, 32'hA5007E01);
    @(negedge clk);
    bus_we = 1'b0;
    check("R5", "second of pair", iw_strobe, 1);
    check("R6", "second word", iw_data, 32'hA5007E02);
    check("R2", "new chan", iw_chan, 8'h0C);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule